// File: doc/BRIEF.md
# Predicated Tile Broadcast Accumulator

This engine adds a source vector into a square accumulator tile held in an external array, one tile element per clock. A pulse on `start` captures the operands: the source vector, a row predicate, a column predicate, the element width and the direction. The engine then walks the tile in row-major order. For each position it reads the current element through a tile port, adds the selected source lane, and writes the sum back through the same port, but only when both predicates enable that position.

In row-broadcast mode the source lane is chosen by the column index, so the same vector is added to every enabled row. In column-broadcast mode the lane is chosen by the row index, so the whole row receives one value. The tile side length follows from the vector length and the element width. With a 32-byte vector this gives 8x8 for 32-bit elements and 4x4 for 64-bit elements. The read side of the tile port is combinational, and writes land on the next rising clock edge. A one-cycle `done` pulse marks the end of the pass.

Top module: `tile_bcast_add`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `tile_we` are low until a `start` is accepted.
- R2: A `start` seen while idle captures all operands (source, both predicates, `vert_mode`, `wide_mode`) in that cycle. Later changes to those inputs have no effect on the running pass, and a `start` seen while busy is ignored.
- R3: After an accepted `start`, `busy` is high for exactly DIM*DIM cycles. DIM is VEC_BYTES/4 for 32-bit elements (`wide_mode`=0) and VEC_BYTES/8 for 64-bit elements (`wide_mode`=1). The pass presents `tile_row`/`tile_col` in row-major order starting at (0,0), one position per cycle.
- R4: `done` is high for exactly one cycle, the cycle right after the last position, and `busy` is low in that cycle.
- R5: `tile_we` is high only in a visited cycle where both the row predicate bit of `tile_row` and the column predicate bit of `tile_col` are set. Positions without both bits are never written.
- R6: The governing predicate bit for index i is bit 4*i for 32-bit elements and bit 8*i for 64-bit elements. All other predicate bits are ignored.
- R7: With `vert_mode`=0, the addend for position (row,col) is source lane col.
- R8: With `vert_mode`=1, the addend for position (row,col) is source lane row, for every column of that row.
- R9: Source lane i occupies bits [W*i +: W], with W=32 or 64. The sum wraps modulo 2^W. In 32-bit mode only `tile_rdata[31:0]` is used and `tile_wdata[63:32]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (accepted when idle) |
| vert_mode | input | 1 | 0: lane follows column; 1: lane follows row |
| wide_mode | input | 1 | 0: 32-bit elements; 1: 64-bit elements |
| src_vec | input | VEC_BYTES*8 | Source vector |
| row_pred | input | VEC_BYTES | Row predicate, one bit per byte |
| col_pred | input | VEC_BYTES | Column predicate, one bit per byte |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| tile_row | output | log2(VEC_BYTES/4) | Row of the visited element |
| tile_col | output | log2(VEC_BYTES/4) | Column of the visited element |
| tile_rdata | input | 64 | Current element at (tile_row, tile_col), combinational |
| tile_we | output | 1 | Write the visited element |
| tile_wdata | output | 64 | Updated element value |

## Verification
Assertions watch the control skeleton on every cycle:
- writes occur only during a pass;
- each pass starts at (0,0);
- the column index steps by one;
- 64-bit passes stay within the smaller tile;
- `done` is a single pulse that closes a pass.

Only the bench scenarios can show the data behaviour, checked against a behavioural reference model:
- the lane chosen in each mode;
- the predicate bit positions at both widths;
- wrap-around and upper-half clearing;
- that operands are held from `start`.

// File: rtl/tba_pkg.sv
package tba_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int WORD_W   = 64;
    localparam int NARROW_W = 32;
endpackage

// File: rtl/tba_lane_pick.sv
// Selects source lane idx at 32-bit or 64-bit granularity.
module tba_lane_pick #(
    parameter int VEC_BYTES = 32,
    parameter int IDX_W     = 3
) (
    input  logic [VEC_BYTES*8-1:0] src,
    input  logic                   wide,
    input  logic [IDX_W-1:0]       idx,
    output logic [63:0]            lane
);
    localparam int N32   = VEC_BYTES / 4;
    localparam int N64   = VEC_BYTES / 8;
    localparam int I64_W = $clog2(N64);

    logic [31:0] lanes32 [N32];
    logic [63:0] lanes64 [N64];

    generate
        for (genvar i = 0; i < N32; i++) begin : g_n
            assign lanes32[i] = src[32*i +: 32];
        end
        for (genvar j = 0; j < N64; j++) begin : g_w
            assign lanes64[j] = src[64*j +: 64];
        end
    endgenerate

    always_comb begin
        if (wide) lane = lanes64[idx[I64_W-1:0]];
        else      lane = {32'b0, lanes32[idx]};
    end
endmodule

// File: rtl/tba_pred_pick.sv
// Returns the governing predicate bit for element index idx.
module tba_pred_pick #(
    parameter int VEC_BYTES = 32,
    parameter int IDX_W     = 3
) (
    input  logic [VEC_BYTES-1:0] pred,
    input  logic                 wide,
    input  logic [IDX_W-1:0]     idx,
    output logic                 bit_on
);
    localparam int POS_W = $clog2(VEC_BYTES);

    logic [POS_W-1:0] pos;

    always_comb begin
        if (wide) pos = POS_W'(idx) << 3;
        else      pos = POS_W'(idx) << 2;
        bit_on = pred[pos];
    end
endmodule

// File: rtl/tba_adder.sv
// Wrap-around adder; narrow mode clears the upper half.
module tba_adder #(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              wide,
    input  logic [WIDE_W-1:0] acc,
    input  logic [WIDE_W-1:0] addend,
    output logic [WIDE_W-1:0] sum
);
    always_comb begin
        if (wide) sum = acc + addend;
        else      sum = {{(WIDE_W-NARROW_W){1'b0}}, acc[NARROW_W-1:0] + addend[NARROW_W-1:0]};
    end
endmodule

// File: rtl/tile_bcast_add.sv
module tile_bcast_add
    import tba_pkg::*;
#(
    parameter  int VEC_BYTES = 32,
    localparam int VEC_BITS  = VEC_BYTES * 8,
    localparam int IDX_W     = $clog2(VEC_BYTES / 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 vert_mode,
    input  logic                 wide_mode,
    input  logic [VEC_BITS-1:0]  src_vec,
    input  logic [VEC_BYTES-1:0] row_pred,
    input  logic [VEC_BYTES-1:0] col_pred,
    output logic                 busy,
    output logic                 done,
    output logic [IDX_W-1:0]     tile_row,
    output logic [IDX_W-1:0]     tile_col,
    input  logic [63:0]          tile_rdata,
    output logic                 tile_we,
    output logic [63:0]          tile_wdata
);
    localparam int DIM32 = VEC_BYTES / 4;
    localparam int DIM64 = VEC_BYTES / 8;

    typedef struct packed {
        phase_e               phase;
        logic                 done;
        logic                 vert;
        logic                 wide;
        logic [VEC_BITS-1:0]  src;
        logic [VEC_BYTES-1:0] rp;
        logic [VEC_BYTES-1:0] cp;
        logic [IDX_W-1:0]     row;
        logic [IDX_W-1:0]     col;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        last_idx   = ctl_q.wide ? IDX_W'(DIM64 - 1) : IDX_W'(DIM32 - 1);
        case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.phase = PH_RUN;
                    ctl_d.vert  = vert_mode;
                    ctl_d.wide  = wide_mode;
                    ctl_d.src   = src_vec;
                    ctl_d.rp    = row_pred;
                    ctl_d.cp    = col_pred;
                    ctl_d.row   = '0;
                    ctl_d.col   = '0;
                end
            end
            default: begin
                if (ctl_q.col == last_idx) begin
                    ctl_d.col = '0;
                    if (ctl_q.row == last_idx) begin
                        ctl_d.row   = '0;
                        ctl_d.phase = PH_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.row = ctl_q.row + 1'b1;
                    end
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [IDX_W-1:0] lane_idx;
    logic [63:0]      addend;
    logic             row_on, col_on;

    assign lane_idx = ctl_q.vert ? ctl_q.row : ctl_q.col;

    tba_lane_pick #(.VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) u_lane (
        .src (ctl_q.src),
        .wide(ctl_q.wide),
        .idx (lane_idx),
        .lane(addend)
    );

    tba_pred_pick #(.VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) u_prow (
        .pred  (ctl_q.rp),
        .wide  (ctl_q.wide),
        .idx   (ctl_q.row),
        .bit_on(row_on)
    );

    tba_pred_pick #(.VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) u_pcol (
        .pred  (ctl_q.cp),
        .wide  (ctl_q.wide),
        .idx   (ctl_q.col),
        .bit_on(col_on)
    );

    tba_adder #(.WIDE_W(WORD_W), .NARROW_W(NARROW_W)) u_add (
        .wide  (ctl_q.wide),
        .acc   (tile_rdata),
        .addend(addend),
        .sum   (tile_wdata)
    );

    assign busy     = (ctl_q.phase == PH_RUN);
    assign done     = ctl_q.done;
    assign tile_row = ctl_q.row;
    assign tile_col = ctl_q.col;
    assign tile_we  = busy && row_on && col_on;

    AST_WE_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        tile_we |-> busy); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4
    AST_PASS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tile_row == '0 && tile_col == '0)); // R3
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && tile_col != '0) |-> (tile_col == IDX_W'($past(tile_col) + 1'b1))); // R3
    AST_WIDE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.wide) |-> (tile_row < IDX_W'(DIM64) && tile_col < IDX_W'(DIM64))); // R3
endmodule

// File: tb/tile_bcast_add_tb.sv
module tile_bcast_add_tb;
    localparam int VEC_BYTES = 32;
    localparam int VEC_BITS  = VEC_BYTES * 8;
    localparam int IDX_W     = $clog2(VEC_BYTES / 4);
    localparam int DIM32     = VEC_BYTES / 4;
    localparam int DIM64     = VEC_BYTES / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, vert_mode = 1'b0, wide_mode = 1'b0;
    logic [VEC_BITS-1:0]  src_vec = '0;
    logic [VEC_BYTES-1:0] row_pred = '0, col_pred = '0;
    logic busy, done, tile_we;
    logic [IDX_W-1:0] tile_row, tile_col;
    logic [63:0] tile_rdata, tile_wdata;

    always #2.5 clk = ~clk;

    tile_bcast_add #(.VEC_BYTES(VEC_BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vert_mode(vert_mode),
        .wide_mode(wide_mode), .src_vec(src_vec), .row_pred(row_pred),
        .col_pred(col_pred), .busy(busy), .done(done), .tile_row(tile_row),
        .tile_col(tile_col), .tile_rdata(tile_rdata), .tile_we(tile_we),
        .tile_wdata(tile_wdata)
    );

    // tile storage
    logic [63:0] mem [0:DIM32-1][0:DIM32-1];
    logic        fill_en = 1'b0;
    logic [31:0] fill_seed = '0;
    assign tile_rdata = mem[tile_row][tile_col];

    function automatic logic [63:0] fill_val(logic [31:0] s, int r, int c);
        if (s == 0) return '1;
        return 64'(s) * 64'h0000_0001_0000_0001 + 64'(r * 256 + c) + 64'hA5A5_0000_0000_0000;
    endfunction

    always @(posedge clk) begin
        if (fill_en) begin
            for (int r = 0; r < DIM32; r++)
                for (int c = 0; c < DIM32; c++)
                    mem[r][c] <= fill_val(fill_seed, r, c);
        end else if (tile_we) begin
            mem[tile_row][tile_col] <= tile_wdata;
        end
    end

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit checking = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_of(logic [VEC_BITS-1:0] v, bit wide, int idx);
        if (wide) return 64'(v >> (64 * idx));
        return {32'h0, 32'(v >> (32 * idx))};
    endfunction

    function automatic bit pbit(logic [VEC_BYTES-1:0] p, bit wide, int idx);
        return p[idx * (wide ? 8 : 4)];
    endfunction

    // behavioural reference model
    bit m_busy = 0, m_done = 0, m_vert = 0, m_wide = 0;
    logic [VEC_BITS-1:0]  m_src = '0;
    logic [VEC_BYTES-1:0] m_rp = '0, m_cp = '0;
    int m_r = 0, m_c = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_r = 0; m_c = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                int dim;
                dim = m_wide ? DIM64 : DIM32;
                if (m_c == dim - 1) begin
                    m_c = 0;
                    if (m_r == dim - 1) begin
                        m_busy = 0; m_done = 1; m_r = 0;
                    end else m_r++;
                end else m_c++;
            end else if (start) begin
                m_busy = 1; m_r = 0; m_c = 0;
                m_vert = vert_mode; m_wide = wide_mode;
                m_src = src_vec; m_rp = row_pred; m_cp = col_pred;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && checking) begin
            chk(busy == m_busy, "R3 busy length", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R4 done pulse", 64'(done), 64'(m_done));
            if (m_busy) begin
                bit e_we;
                chk(tile_row == m_r[IDX_W-1:0], "R3 row order", 64'(tile_row), 64'(m_r));
                chk(tile_col == m_c[IDX_W-1:0], "R3 col order", 64'(tile_col), 64'(m_c));
                e_we = pbit(m_rp, m_wide, m_r) && pbit(m_cp, m_wide, m_c);
                chk(tile_we == e_we, "R5 R6 predicate gate", 64'(tile_we), 64'(e_we));
                if (e_we) begin
                    logic [63:0] a, cur, e;
                    a   = lane_of(m_src, m_wide, m_vert ? m_r : m_c);
                    cur = mem[m_r][m_c];
                    e   = m_wide ? cur + a : {32'h0, cur[31:0] + a[31:0]};
                    chk(tile_wdata == e, m_vert ? "R8 R9 vertical sum" : "R7 R9 horizontal sum",
                        tile_wdata, e);
                end
            end else begin
                chk(tile_we == 1'b0, "R5 idle write", 64'(tile_we), 64'd0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [VEC_BITS-1:0] mk_src(logic [31:0] s);
        logic [VEC_BITS-1:0] v;
        for (int i = 0; i < VEC_BYTES / 4; i++)
            v[32*i +: 32] = (s * 32'h0100_0193 + 32'(i) * 32'h9E37_79B9) ^ (32'hF0F0_0000 * 32'(i));
        return v;
    endfunction

    task automatic fill(input logic [31:0] s);
        fill_seed = s; fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic run_op(input bit v, input bit w, input logic [VEC_BITS-1:0] s,
                          input logic [VEC_BYTES-1:0] rp, input logic [VEC_BYTES-1:0] cp,
                          input bit intrude);
        vert_mode = v; wide_mode = w; src_vec = s; row_pred = rp; col_pred = cp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: operands changed after capture must not matter
        src_vec = ~s; row_pred = ~rp; col_pred = ~cp; vert_mode = ~v; wide_mode = ~w;
        if (intrude) begin
            @(negedge clk);
            start = 1'b1;  // R2: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
        chk(tile_we == 1'b0, "R1 reset we", 64'(tile_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", 64'(busy), 64'd0);
        checking = 1'b1;

        fill(32'd1);
        run_op(1'b0, 1'b0, mk_src(32'd1), '1, '1, 1'b0);                          // R7 32-bit full
        fill(32'd2);
        run_op(1'b1, 1'b0, mk_src(32'd2), 32'h1001_0110, 32'h0110_1011, 1'b0);     // R8 sparse
        run_op(1'b0, 1'b0, mk_src(32'd3), 32'hEEEE_EEEE, '1, 1'b0);                // R6 no governing bits
        run_op(1'b1, 1'b1, mk_src(32'd4), 32'h0101_0101, 32'h0000_0001, 1'b0);     // R6 64-bit positions
        run_op(1'b0, 1'b1, mk_src(32'd5), 32'hFEFE_FEFE, '1, 1'b0);                // R6 64-bit none
        fill(32'd0);
        run_op(1'b0, 1'b1, '1, '1, '1, 1'b0);                                      // R9 64-bit wrap
        run_op(1'b1, 1'b0, '1, '1, '1, 1'b0);                                      // R9 32-bit wrap
        fill(32'd7);
        run_op(1'b1, 1'b1, mk_src(32'd6), 32'h0100_0101, 32'h0101_0001, 1'b1);     // R2 intrusion
        run_op(1'b0, 1'b0, mk_src(32'd8), 32'h0F1F_2F3F, 32'h1111_0000, 1'b1);     // R2 back-to-back
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R4 quiet after pass", 64'({busy, done}), 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule